// File: doc/BRIEF.md
# Power-Down and Self-Refresh Sequencer

This block sits on the controller side of a DRAM interface. It drives the memory's active-low power-down pin and asks the command path to issue the commands that put the device into power-down or self-refresh and bring it back out. Requests to enter a low-power state are kept until every bank is idle and the data pins are released to high impedance. No request is lost. All waiting periods are counted in controller clock cycles.

Self-refresh entry uses the same two-command pair as an auto-refresh: a write-activate, then refresh on the next clock. The pin is pulled low a fixed number of clocks after the refresh command. The sequencer compares the caller's time-since-last-refresh counter with the allowed entry window. If the request comes too late, the block first runs an ordinary auto-refresh and then starts the entry again. After self-refresh exit it pulses a flag so the refresh scheduler issues the required auto-refresh. Power-down exit and self-refresh exit hold deselect for different lengths.

Top module: `lp_mode_seq`

## Requirements
- R1: After reset, `pd_n_o` is 1, `cmd_o` is deselect, `ready_o` is 1 and `ref_due_o` is 0. `cmd_o` encoding: 0 = deselect, 1 = write-activate, 2 = refresh.
- R2: Suppose a power-down request is seen at a clock edge while `banks_idle_i` and `dq_hiz_i` are both 1. Then from that edge `pd_n_o` is 0, `cmd_o` is deselect and `ready_o` is 0.
- R3: A power-down or self-refresh request seen while `banks_idle_i` or `dq_hiz_i` is 0 is stored. `ready_o` stays 1 and the pin stays high. The request is carried out at the first edge where both flags are 1.
- R4: In power-down, a wake request makes `pd_n_o` 1 from the next edge. Deselect with `ready_o` at 0 lasts PD_EXIT_CYC cycles, and then `ready_o` returns to 1.
- R5: A self-refresh request that is granted with `refresh_age_i` below SR_WINDOW_CYC-2-SR_PD_DLY gives one cycle of write-activate, then one cycle of refresh. The pin goes low SR_PD_DLY cycles after the refresh cycle, and deselect is driven in between.
- R6: Once the pin is low in self-refresh, it stays low with deselect for at least REFC_CYC cycles, even if wake is requested earlier. It then stays low until a wake request has been seen.
- R7: Self-refresh exit raises the pin with deselect for REFC_CYC cycles. In the first cycle that `ready_o` is 1 again, `ref_due_o` is 1, for that cycle only.
- R8: A self-refresh request that is granted with `refresh_age_i` at or above SR_WINDOW_CYC-2-SR_PD_DLY gives write-activate, then refresh, then REFC_CYC cycles of deselect with the pin high. After one ready cycle, entry is evaluated again.
- R9: A wake request while `ready_o` is 1 has no effect and is not kept for a later low-power period.
- R10: When self-refresh and power-down are both pending, self-refresh goes first. The power-down request is kept and starts right after the self-refresh exit completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_req_i | input | 1 | Request to enter power-down |
| sr_req_i | input | 1 | Request to enter self-refresh |
| wake_req_i | input | 1 | Request to leave the current low-power state |
| banks_idle_i | input | 1 | All banks are idle |
| dq_hiz_i | input | 1 | Data outputs are in high impedance |
| refresh_age_i | input | AGE_W | Cycles since the most recent auto-refresh |
| pd_n_o | output | 1 | Power-down pin level, low = low-power |
| cmd_o | output | 2 | Command to drive: 0 deselect, 1 write-activate, 2 refresh |
| ready_o | output | 1 | Sequencer idle, command bus free for normal traffic |
| ref_due_o | output | 1 | One-cycle pulse: issue an auto-refresh now |

## Verification
Every output is decoded from registered state. A request or wake that is present at a clock edge therefore shows on `pin`, `cmd_o` and `ready_o` right after that same edge. Each timed phase then lasts exactly its parameter count, and `ref_due_o` rises together with the return of `ready_o`. The bench drives inputs just after a rising edge. For each cycle it queues the output values due after the next edge, tagged with that cycle's number, and the monitor compares them at the falling edge of exactly that cycle. Because of this, a phase that is one cycle short or long shows up as a mismatch in the cycle where the lengths differ.

// File: rtl/lp_mode_pkg.sv
package lp_mode_pkg;

  typedef enum logic [1:0] {
    CMD_DESL = 2'd0,
    CMD_WRA  = 2'd1,
    CMD_REF  = 2'd2
  } lp_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PD_LOW,
    ST_PD_EXIT,
    ST_AR_WRA,
    ST_AR_REF,
    ST_AR_WAIT,
    ST_SR_WRA,
    ST_SR_REF,
    ST_SR_GAP,
    ST_SR_HOLD,
    ST_SR_SLEEP,
    ST_SR_EXIT
  } lp_state_e;

  localparam int REQ_PD   = 0;
  localparam int REQ_SR   = 1;
  localparam int REQ_WAKE = 2;
  localparam int REQ_N    = 3;

endpackage

// File: rtl/lp_req_hold.sv
module lp_req_hold #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] pend_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= (pend_q[g] | req_i[g]) & ~clr_i[g];
    end
    assign pend_o[g] = pend_q[g] | req_i[g];

    // R3: a stored request survives until it is taken
    p_held_until_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
  end

endmodule

// File: rtl/lp_down_cnt.sv
module lp_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R6: count moves down one step per cycle when not reloaded
  p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
  import lp_mode_pkg::*;
#(
  parameter int AGE_W       = 12,
  parameter int CNT_W       = 5,
  parameter int SR_LATE_AGE = 776,
  parameter int SR_PD_DLY   = 2,
  parameter int REFC_CYC    = 16,
  parameter int PD_EXIT_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_want_i,
  input  logic             sr_want_i,
  input  logic             wake_want_i,
  input  logic             idle_ok_i,
  input  logic [AGE_W-1:0] age_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic [REQ_N-1:0] clr_o,
  output logic             wake_arm_o,
  output logic             pd_n_o,
  output logic [1:0]       cmd_o,
  output logic             ready_o,
  output logic             ref_due_o
);

  localparam logic [CNT_W-1:0] L_REFC = CNT_W'(REFC_CYC - 1);
  localparam logic [CNT_W-1:0] L_PDX  = CNT_W'(PD_EXIT_CYC - 1);
  localparam logic [CNT_W-1:0] L_GAP  = CNT_W'((SR_PD_DLY > 1) ? SR_PD_DLY - 2 : 0);
  localparam logic [AGE_W-1:0] LATE   = AGE_W'(SR_LATE_AGE);

  lp_state_e state_q, state_d;
  logic      ref_due_q;
  logic      late;

  assign late = (age_i >= LATE);

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    clr_o      = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (sr_want_i && idle_ok_i) begin
          if (late) begin
            state_d = ST_AR_WRA;
          end else begin
            state_d         = ST_SR_WRA;
            clr_o[REQ_SR]   = 1'b1;
          end
        end else if (pd_want_i && idle_ok_i) begin
          state_d       = ST_PD_LOW;
          clr_o[REQ_PD] = 1'b1;
        end
      end
      ST_PD_LOW: begin
        if (wake_want_i) begin
          state_d         = ST_PD_EXIT;
          cnt_load_o      = 1'b1;
          cnt_val_o       = L_PDX;
          clr_o[REQ_WAKE] = 1'b1;
        end
      end
      ST_PD_EXIT: if (cnt_zero_i) state_d = ST_IDLE;
      ST_AR_WRA:  state_d = ST_AR_REF;
      ST_AR_REF: begin
        state_d    = ST_AR_WAIT;
        cnt_load_o = 1'b1;
        cnt_val_o  = L_REFC;
      end
      ST_AR_WAIT: if (cnt_zero_i) state_d = ST_IDLE;
      ST_SR_WRA:  state_d = ST_SR_REF;
      ST_SR_REF: begin
        cnt_load_o = 1'b1;
        if (SR_PD_DLY > 1) begin
          state_d   = ST_SR_GAP;
          cnt_val_o = L_GAP;
        end else begin
          state_d   = ST_SR_HOLD;
          cnt_val_o = L_REFC;
        end
      end
      ST_SR_GAP: begin
        if (cnt_zero_i) begin
          state_d    = ST_SR_HOLD;
          cnt_load_o = 1'b1;
          cnt_val_o  = L_REFC;
        end
      end
      ST_SR_HOLD: begin
        if (cnt_zero_i) begin
          if (wake_want_i) begin
            state_d         = ST_SR_EXIT;
            cnt_load_o      = 1'b1;
            cnt_val_o       = L_REFC;
            clr_o[REQ_WAKE] = 1'b1;
          end else begin
            state_d = ST_SR_SLEEP;
          end
        end
      end
      ST_SR_SLEEP: begin
        if (wake_want_i) begin
          state_d         = ST_SR_EXIT;
          cnt_load_o      = 1'b1;
          cnt_val_o       = L_REFC;
          clr_o[REQ_WAKE] = 1'b1;
        end
      end
      ST_SR_EXIT: if (cnt_zero_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ref_due_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      ref_due_q <= (state_q == ST_SR_EXIT) && cnt_zero_i;
    end
  end

  // Wake is only meaningful once a low-power sequence has started
  assign wake_arm_o = (state_q inside {ST_PD_LOW, ST_SR_WRA, ST_SR_REF,
                                       ST_SR_GAP, ST_SR_HOLD, ST_SR_SLEEP});
  assign pd_n_o     = !(state_q inside {ST_PD_LOW, ST_SR_HOLD, ST_SR_SLEEP});
  assign ready_o    = (state_q == ST_IDLE);
  assign ref_due_o  = ref_due_q;

  always_comb begin
    unique case (state_q)
      ST_AR_WRA, ST_SR_WRA: cmd_o = CMD_WRA;
      ST_AR_REF, ST_SR_REF: cmd_o = CMD_REF;
      default:              cmd_o = CMD_DESL;
    endcase
  end

  // Checker state: length of the current low-pin run, saturating
  logic [CNT_W:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  low_run_q <= '0;
    else if (pd_n_o)                              low_run_q <= '0;
    else if (low_run_q < (CNT_W+1)'(REFC_CYC))    low_run_q <= low_run_q + 1'b1;
  end

  // R2: direct drop from ready only when idle conditions held
  p_pd_entry_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pd_n_o) && $past(ready_o)) |-> $past(idle_ok_i));

  // R5: write-activate is always followed by refresh
  p_wra_then_ref_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_WRA) |=> (cmd_o == CMD_REF));

  // R8: a command pair only starts from the ready state
  p_wra_after_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_WRA) |-> $past(ready_o));

  // R4: pin rises with deselect, deselect continues next cycle
  p_exit_desl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_n_o) |-> (cmd_o == CMD_DESL) ##1 (cmd_o == CMD_DESL));

  // R6: self-refresh pin-low run reaches the recovery count
  p_sr_hold_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pd_n_o) && state_q == ST_SR_EXIT) |-> (low_run_q >= (CNT_W+1)'(REFC_CYC)));

  // R7: refresh-due pulse only right after self-refresh recovery
  p_due_after_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_due_o |-> (ready_o && $past(state_q == ST_SR_EXIT)));

endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
  import lp_mode_pkg::*;
#(
  parameter int AGE_W         = 12,
  parameter int SR_WINDOW_CYC = 780,
  parameter int SR_PD_DLY     = 2,
  parameter int REFC_CYC      = 16,
  parameter int PD_EXIT_CYC   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_req_i,
  input  logic             sr_req_i,
  input  logic             wake_req_i,
  input  logic             banks_idle_i,
  input  logic             dq_hiz_i,
  input  logic [AGE_W-1:0] refresh_age_i,
  output logic             pd_n_o,
  output logic [1:0]       cmd_o,
  output logic             ready_o,
  output logic             ref_due_o
);

  localparam int MAX_A       = (REFC_CYC > PD_EXIT_CYC) ? REFC_CYC : PD_EXIT_CYC;
  localparam int MAX_C       = (MAX_A > SR_PD_DLY) ? MAX_A : SR_PD_DLY;
  localparam int CNT_W       = $clog2(MAX_C + 1);
  // Entry takes WRA + REF + pin delay; start late enough and it misses the window
  localparam int SR_LATE_AGE = SR_WINDOW_CYC - 2 - SR_PD_DLY;

  logic [REQ_N-1:0] req, clr, pend;
  logic             wake_arm, cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;

  assign req[REQ_PD]   = pd_req_i;
  assign req[REQ_SR]   = sr_req_i;
  assign req[REQ_WAKE] = wake_req_i & wake_arm;

  lp_req_hold #(.N(REQ_N)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .clr_i  (clr),
    .pend_o (pend)
  );

  lp_down_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .zero_o (cnt_zero)
  );

  lp_seq_fsm #(
    .AGE_W       (AGE_W),
    .CNT_W       (CNT_W),
    .SR_LATE_AGE (SR_LATE_AGE),
    .SR_PD_DLY   (SR_PD_DLY),
    .REFC_CYC    (REFC_CYC),
    .PD_EXIT_CYC (PD_EXIT_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pd_want_i   (pend[REQ_PD]),
    .sr_want_i   (pend[REQ_SR]),
    .wake_want_i (pend[REQ_WAKE]),
    .idle_ok_i   (banks_idle_i & dq_hiz_i),
    .age_i       (refresh_age_i),
    .cnt_zero_i  (cnt_zero),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val),
    .clr_o       (clr),
    .wake_arm_o  (wake_arm),
    .pd_n_o      (pd_n_o),
    .cmd_o       (cmd_o),
    .ready_o     (ready_o),
    .ref_due_o   (ref_due_o)
  );

endmodule

// File: tb/lp_mode_seq_tb.sv
`timescale 1ns/1ps
module lp_mode_seq_tb;
  import lp_mode_pkg::*;

  localparam int AGE_W = 8;
  localparam int WIN   = 40;
  localparam int DLY   = 2;
  localparam int REFC  = 4;
  localparam int PDX   = 2;
  localparam int LATE  = WIN - 2 - DLY;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 0, sr_req = 0, wake_req = 0, banks_idle = 1, dq_hiz = 1;
  logic [AGE_W-1:0] age = '0;
  logic pd_n, ready, due;
  logic [1:0] cmd;

  always #2.5 clk = ~clk;

  lp_mode_seq #(
    .AGE_W(AGE_W), .SR_WINDOW_CYC(WIN), .SR_PD_DLY(DLY),
    .REFC_CYC(REFC), .PD_EXIT_CYC(PDX)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(pd_req), .sr_req_i(sr_req),
    .wake_req_i(wake_req), .banks_idle_i(banks_idle), .dq_hiz_i(dq_hiz),
    .refresh_age_i(age), .pd_n_o(pd_n), .cmd_o(cmd), .ready_o(ready),
    .ref_due_o(due)
  );

  typedef struct {
    int unsigned cyc;
    logic        pd_n;
    logic [1:0]  cmd;
    logic        rdy;
    logic        due;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int unsigned cyc_cnt = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // Monitor: compare queued expectations in their own cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc == cyc_cnt) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pd_n !== e.pd_n || cmd !== e.cmd || ready !== e.rdy || due !== e.due) begin
        fails++;
        $display("FAIL %s: got pd_n=%b cmd=%0d ready=%b due=%b, want pd_n=%b cmd=%0d ready=%b due=%b",
                 e.tag, pd_n, cmd, ready, due, e.pd_n, e.cmd, e.rdy, e.due);
      end
    end
  end

  // Driver: queue outputs due after the next edge, then pass that edge
  task automatic step(input logic p, input logic [1:0] c, input logic r,
                      input logic d, input string tag);
    exp_t e;
    e.cyc = cyc_cnt + 1; e.pd_n = p; e.cmd = c; e.rdy = r; e.due = d; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic idle(input string t); step(1'b1, CMD_DESL, 1'b1, 1'b0, t); endtask
  task automatic low(input string t);  step(1'b0, CMD_DESL, 1'b0, 1'b0, t); endtask
  task automatic hi(input string t);   step(1'b1, CMD_DESL, 1'b0, 1'b0, t); endtask
  task automatic wra(input string t);  step(1'b1, CMD_WRA,  1'b0, 1'b0, t); endtask
  task automatic rf(input string t);   step(1'b1, CMD_REF,  1'b0, 1'b0, t); endtask
  task automatic duec(input string t); step(1'b1, CMD_DESL, 1'b1, 1'b1, t); endtask

  task automatic pd_wake(input string t);
    wake_req = 1; hi({t, " R4 exit c1"});
    wake_req = 0; hi({t, " R4 exit c2"});
    idle({t, " R4 ready"});
  endtask

  // From the cycle after REF: gap, REFC low cycles
  task automatic sr_body(input string t);
    hi({t, " R5 gap"});
    for (int i = 0; i < REFC; i++) low({t, " R6 hold"});
  endtask

  task automatic sr_exit(input string t);
    for (int i = 0; i < REFC; i++) hi({t, " R7 exit"});
    duec({t, " R7 due"});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, want completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R1 reset state");
    idle("R1 reset state hold");

    // R2 / R4 basic power-down
    pd_req = 1; low("R2 enter");
    pd_req = 0; low("R2 stay"); low("R2 stay");
    pd_wake("pd");

    // R9 wake while ready
    wake_req = 1; idle("R9 wake ignored");
    wake_req = 0; idle("R9 still ready");
    pd_req = 1; low("R9 enter");
    pd_req = 0; low("R9 no stale wake"); low("R9 no stale wake");
    pd_wake("r9");

    // R3 held while not idle
    banks_idle = 0; pd_req = 1; idle("R3 held banks busy");
    pd_req = 0; idle("R3 held banks busy");
    dq_hiz = 0; banks_idle = 1; idle("R3 held outputs driven");
    dq_hiz = 1; low("R3 granted");
    pd_wake("r3");

    // R5/R6/R7 self-refresh, early wake during hold
    sr_req = 1; wra("R5 wra");
    sr_req = 0; rf("R5 ref");
    hi("R5 gap");
    low("R6 h1");
    wake_req = 1; low("R6 early wake h2");
    wake_req = 0; low("R6 h3"); low("R6 h4");
    sr_exit("sr1");
    idle("R7 due once");

    // R6 stays low until wake; age just under limit (R5 boundary)
    age = AGE_W'(LATE - 1);
    sr_req = 1; wra("R5 boundary wra");
    sr_req = 0; rf("R5 boundary ref");
    sr_body("sr2");
    low("R6 sleep"); low("R6 sleep"); low("R6 sleep");
    age = '0;
    wake_req = 1; hi("R7 exit c1");
    wake_req = 0;
    for (int i = 1; i < REFC; i++) hi("R7 exit");
    duec("R7 due");
    idle("R7 due once");

    // R8 late request: auto-refresh first, then retry
    age = AGE_W'(LATE);
    sr_req = 1; wra("R8 wra");
    sr_req = 0; rf("R8 ref");
    age = '0;
    for (int i = 0; i < REFC; i++) hi("R8 pin high recovery");
    idle("R8 back ready");
    wra("R8 retry wra"); rf("R8 retry ref");
    sr_body("r8");
    wake_req = 1; hi("R8 exit c1");
    wake_req = 0;
    for (int i = 1; i < REFC; i++) hi("R8 exit");
    duec("R8 due");
    idle("R8 ready");

    // R10 both pending: self-refresh first, power-down kept
    pd_req = 1; sr_req = 1; wra("R10 sr first");
    pd_req = 0; sr_req = 0; rf("R10 ref");
    sr_body("r10");
    wake_req = 1; hi("R10 exit c1");
    wake_req = 0;
    for (int i = 1; i < REFC; i++) hi("R10 exit");
    duec("R10 due");
    low("R10 pd kept");
    pd_wake("r10");
    idle("R1 final idle");

    @(negedge clk); #1;
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R1 scoreboard drain: got %0d left, want 0", sb.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule